// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block holds ten byte-wide configuration registers at offsets 3h through Ch, reached through a plain address/data port that a serial front end drives. Every write takes effect on the clock edge that samples it. Reads are combinational from the address. Each register has its own reset value and its own mask of writable bits. Bits outside the mask always read zero. The stored bits are decoded into named parallel outputs that the rest of the chip uses directly.

Offset 3h carries a 3-bit lock code. Code 110b freezes the configuration, so writes to any other offset are dropped until code 011b is written. Offset 4h bit 0 is a self-clearing command bit. Writing a one to it produces a single-cycle fault-clear strobe and stores nothing.

Top module: `cfgb_bank`

## Requirements
- R1: After reset the bank is unlocked, the strobe is low, and reads return 00h at 3h, 80h at 4h, 46h at 5h, 10h at 6h and 00h at offsets 7h through Ch.
- R2: A write stores only the writable bits, and all other bits read 0. The writable masks are: 4h FEh, 5h 7Fh, 6h FFh, 7h FFh, 8h 3Fh, 9h 1Fh, Ah DFh, Bh 07h, Ch 1Fh. A register keeps its value when it is not written.
- R3: Reserved bits that are writable keep the value written to them. These are bits 7..6 at 4h and bits 6 and 1 at 5h.
- R4: Writing code 110b to bits 2..0 of offset 3h locks the bank from the next cycle on. `bank_locked` then reads 1.
- R5: While the bank is locked, writes to offsets 4h through Ch change no register and raise no fault-clear strobe.
- R6: Writes to offset 3h are accepted whether or not the bank is locked. Code 011b unlocks the bank, and later writes to other offsets take effect again.
- R7: Any code other than 110b and 011b leaves the lock state unchanged. Offset 3h reads back the last code written in bits 2..0 and zero in bits 7..3.
- R8: A write of 1 to bit 0 of 4h, when the bank is unlocked, drives `clr_fault_pulse` high for exactly the one cycle after the write edge. Bit 0 of 4h always reads 0.
- R9: Offsets outside 3h..Ch read 00h, and writes to them change no register and no lock state.
- R10: The field outputs follow the stored bits. For example, `dir_reverse` is bit 0 of 9h, `ocp_action` is bits 1..0 of 6h, `ocp_deglitch` is bits 5..4 of 6h, `tach_div` is bits 7..6 of Ah, `delay_target` is bits 3..0 of Ch and `delay_comp_en` is bit 4 of Ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| bank_locked | output | 1 | Lock state |
| clr_fault_pulse | output | 1 | One-cycle fault-clear strobe |
| sdo_push_pull | output | 1 | 4h bit 5 |
| slew_sel | output | 2 | 4h bits 4..3 |
| drive_mode | output | 2 | 4h bits 2..1 |
| pwm_full_fast | output | 1 | 5h bit 4 |
| ov_level_low | output | 1 | 5h bit 3 |
| ov_enable | output | 1 | 5h bit 2 |
| warn_report | output | 1 | 5h bit 0 |
| standby_req | output | 1 | 6h bit 7 |
| ocp_cycle_clear | output | 1 | 6h bit 6 |
| ocp_deglitch | output | 2 | 6h bits 5..4 |
| ocp_retry_long | output | 1 | 6h bit 3 |
| ocp_level_high | output | 1 | 6h bit 2 |
| ocp_action | output | 2 | 6h bits 1..0 |
| ilim_coast | output | 1 | 7h bit 6 |
| demag_async_en | output | 1 | 7h bit 3 |
| demag_sync_en | output | 1 | 7h bit 2 |
| csa_gain | output | 2 | 7h bits 1..0 |
| buck_seq_off | output | 1 | 8h bit 4 |
| buck_ilim_low | output | 1 | 8h bit 3 |
| buck_vsel | output | 2 | 8h bits 2..1 |
| buck_off | output | 1 | 8h bit 0 |
| hall_hys_wide | output | 1 | 9h bit 4 |
| brake_coasts | output | 1 | 9h bit 3 |
| coast_cmd | output | 1 | 9h bit 2 |
| brake_cmd | output | 1 | 9h bit 1 |
| dir_reverse | output | 1 | 9h bit 0 |
| tach_div | output | 2 | Ah bits 7..6 |
| stall_retry_long | output | 1 | Ah bit 4 |
| stall_tdet | output | 2 | Ah bits 3..2 |
| stall_action | output | 2 | Ah bits 1..0 |
| advance_sel | output | 3 | Bh bits 2..0 |
| delay_comp_en | output | 1 | Ch bit 4 |
| delay_target | output | 4 | Ch bits 3..0 |

## Verification
A wrong lock state shows up at the next access: `bank_locked` changes, or a write to an ordinary offset either lands or vanishes, and the read one cycle later reveals which. A wrong mask or reset value shows up on the first read of that offset, and it also shows up on the matching field output at once. A strobe that is missing, too long or unblocked differs from the expected value within one or two cycles of the write, so the bench samples `clr_fault_pulse` at both of those cycles.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int DW      = 8;
  localparam int AW      = 4;
  localparam int BASE    = 3;
  localparam int NREG    = 10;
  localparam int CODE_W  = 3;
  localparam logic [CODE_W-1:0] CODE_LOCK   = 3'b110;
  localparam logic [CODE_W-1:0] CODE_UNLOCK = 3'b011;
  localparam int STROBE_IDX = 1;

  // index 0 is the lock slot; indices 1..NREG-1 map to offsets BASE+1..
  function automatic logic [DW-1:0] reg_rst(int idx);
    case (idx)
      1:       return 8'h80;
      2:       return 8'h46;
      3:       return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_mask(int idx);
    case (idx)
      1:       return 8'hFE;
      2:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'hFF;
      5:       return 8'h3F;
      6:       return 8'h1F;
      7:       return 8'hDF;
      8:       return 8'h07;
      9:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgb_rst_sync.sv
module cfgb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cfgb_lock.sv
module cfgb_lock
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              locked_q
);
  logic [CODE_W-1:0] code_nxt;
  logic              locked_nxt;

  always_comb begin
    code_nxt   = code_q;
    locked_nxt = locked_q;
    if (code_we) begin
      code_nxt = code_in;
      if (code_in == CODE_LOCK)   locked_nxt = 1'b1;
      if (code_in == CODE_UNLOCK) locked_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      locked_q <= 1'b0;
    end else if (code_we) begin
      code_q   <= code_nxt;
      locked_q <= locked_nxt;
    end
  end

  // R7
  other_code_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_we && code_in != CODE_LOCK && code_in != CODE_UNLOCK) |=> $stable(locked_q));
  // R4
  lock_code_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_we && code_in == CODE_LOCK) |=> locked_q);
  // R6
  state_held_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_we |=> $stable(locked_q) && $stable(code_q));
endmodule

// File: rtl/cfgb_reg.sv
module cfgb_reg
  import cfgb_pkg::*;
#(
  parameter logic [DW-1:0] RST   = '0,
  parameter logic [DW-1:0] WMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = (d & WMASK) | (RST & ~WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= q_nxt;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~WMASK) == (RST & ~WMASK));
endmodule

// File: rtl/cfgb_bank.sv
module cfgb_bank
  import cfgb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       bank_locked,
  output logic       clr_fault_pulse,
  output logic       sdo_push_pull,
  output logic [1:0] slew_sel,
  output logic [1:0] drive_mode,
  output logic       pwm_full_fast,
  output logic       ov_level_low,
  output logic       ov_enable,
  output logic       warn_report,
  output logic       standby_req,
  output logic       ocp_cycle_clear,
  output logic [1:0] ocp_deglitch,
  output logic       ocp_retry_long,
  output logic       ocp_level_high,
  output logic [1:0] ocp_action,
  output logic       ilim_coast,
  output logic       demag_async_en,
  output logic       demag_sync_en,
  output logic [1:0] csa_gain,
  output logic       buck_seq_off,
  output logic       buck_ilim_low,
  output logic [1:0] buck_vsel,
  output logic       buck_off,
  output logic       hall_hys_wide,
  output logic       brake_coasts,
  output logic       coast_cmd,
  output logic       brake_cmd,
  output logic       dir_reverse,
  output logic [1:0] tach_div,
  output logic       stall_retry_long,
  output logic [1:0] stall_tdet,
  output logic [1:0] stall_action,
  output logic [2:0] advance_sel,
  output logic       delay_comp_en,
  output logic [3:0] delay_target
);
  logic              rst_sync_n;
  logic [NREG-1:0]   hit;
  logic [DW-1:0]     bank [NREG];
  logic [CODE_W-1:0] code_q;
  logic              locked_q;
  logic              strobe_q, strobe_nxt;
  logic [(NREG-1)*DW-1:0] cfg_vec;

  cfgb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // address decode
  always_comb begin
    for (int i = 0; i < NREG; i++) hit[i] = (addr == AW'(BASE + i));
  end

  cfgb_lock u_lock (
    .clk(clk), .rst_n(rst_sync_n),
    .code_we(wr_en && hit[0]),
    .code_in(wdata[CODE_W-1:0]),
    .code_q(code_q), .locked_q(locked_q)
  );

  assign bank[0] = {{(DW-CODE_W){1'b0}}, code_q};

  genvar g;
  generate
    for (g = 1; g < NREG; g++) begin : g_reg
      cfgb_reg #(.RST(reg_rst(g)), .WMASK(reg_mask(g))) u_reg (
        .clk(clk), .rst_n(rst_sync_n),
        .we(wr_en && hit[g] && !locked_q),
        .d(wdata), .q(bank[g])
      );
      assign cfg_vec[(g-1)*DW +: DW] = bank[g];
    end
  endgenerate

  // self-clearing fault-clear strobe
  always_comb begin
    strobe_nxt = wr_en && hit[STROBE_IDX] && !locked_q && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) strobe_q <= 1'b0;
    else             strobe_q <= strobe_nxt;
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) if (hit[i]) rdata = bank[i];
  end

  assign bank_locked     = locked_q;
  assign clr_fault_pulse = strobe_q;

  // field decode
  assign sdo_push_pull    = bank[1][5];
  assign slew_sel         = bank[1][4:3];
  assign drive_mode       = bank[1][2:1];
  assign pwm_full_fast    = bank[2][4];
  assign ov_level_low     = bank[2][3];
  assign ov_enable        = bank[2][2];
  assign warn_report      = bank[2][0];
  assign standby_req      = bank[3][7];
  assign ocp_cycle_clear  = bank[3][6];
  assign ocp_deglitch     = bank[3][5:4];
  assign ocp_retry_long   = bank[3][3];
  assign ocp_level_high   = bank[3][2];
  assign ocp_action       = bank[3][1:0];
  assign ilim_coast       = bank[4][6];
  assign demag_async_en   = bank[4][3];
  assign demag_sync_en    = bank[4][2];
  assign csa_gain         = bank[4][1:0];
  assign buck_seq_off     = bank[5][4];
  assign buck_ilim_low    = bank[5][3];
  assign buck_vsel        = bank[5][2:1];
  assign buck_off         = bank[5][0];
  assign hall_hys_wide    = bank[6][4];
  assign brake_coasts     = bank[6][3];
  assign coast_cmd        = bank[6][2];
  assign brake_cmd        = bank[6][1];
  assign dir_reverse      = bank[6][0];
  assign tach_div         = bank[7][7:6];
  assign stall_retry_long = bank[7][4];
  assign stall_tdet       = bank[7][3:2];
  assign stall_action     = bank[7][1:0];
  assign advance_sel      = bank[8][2:0];
  assign delay_comp_en    = bank[9][4];
  assign delay_target     = bank[9][3:0];

  // R5
  locked_writes_dropped_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked_q && wr_en && !hit[0]) |=> $stable(cfg_vec) && !strobe_q);
  // R8
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strobe_q |-> $past(wr_en && addr == 4'h4 && wdata[0] && !locked_q));
  // R9
  outside_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr < 4'h3 || addr > 4'hC) |-> rdata == 8'h00);
  // R9
  outside_writes_dropped_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (addr < 4'h3 || addr > 4'hC)) |=> $stable(cfg_vec) && $stable(locked_q));
endmodule

// File: tb/cfgb_bank_tb_top.sv
`timescale 1ns/1ps
module cfgb_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic bank_locked, clr_fault_pulse, sdo_push_pull, pwm_full_fast, ov_level_low;
  logic ov_enable, warn_report, standby_req, ocp_cycle_clear, ocp_retry_long;
  logic ocp_level_high, ilim_coast, demag_async_en, demag_sync_en, buck_seq_off;
  logic buck_ilim_low, buck_off, hall_hys_wide, brake_coasts, coast_cmd, brake_cmd;
  logic dir_reverse, stall_retry_long, delay_comp_en;
  logic [1:0] slew_sel, drive_mode, ocp_deglitch, ocp_action, csa_gain, buck_vsel;
  logic [1:0] tach_div, stall_tdet, stall_action;
  logic [2:0] advance_sel;
  logic [3:0] delay_target;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [3:0] adr_q [$];

  always #2 clk = ~clk;

  cfgb_bank dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare queued reads between edges
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      logic [3:0] a;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = adr_q.pop_front();
      chk($sformatf("%s read @%h", t, a), rdata, e);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    wr_en = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag); adr_q.push_back(a);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1
    chk("R1 locked", {7'b0, bank_locked}, 8'h00);
    chk("R1 strobe", {7'b0, clr_fault_pulse}, 8'h00);
    rd(4'h3, 8'h00, "R1"); rd(4'h4, 8'h80, "R1"); rd(4'h5, 8'h46, "R1");
    rd(4'h6, 8'h10, "R1");
    for (int a = 7; a <= 12; a++) rd(4'(a), 8'h00, "R1");
    // R9 reads outside range
    rd(4'h0, 8'h00, "R9"); rd(4'h2, 8'h00, "R9"); rd(4'hD, 8'h00, "R9"); rd(4'hF, 8'h00, "R9");

    // R2 / R3 masks
    for (int a = 4; a <= 12; a++) wr(4'(a), 8'hFF);
    rd(4'h4, 8'hFE, "R3"); rd(4'h5, 8'h7F, "R3");
    rd(4'h6, 8'hFF, "R2"); rd(4'h7, 8'hFF, "R2"); rd(4'h8, 8'h3F, "R2");
    rd(4'h9, 8'h1F, "R2"); rd(4'hA, 8'hDF, "R2"); rd(4'hB, 8'h07, "R2");
    rd(4'hC, 8'h1F, "R2");
    wr(4'h5, 8'h42);
    rd(4'h5, 8'h42, "R3");
    wr(4'h4, 8'hC0);
    rd(4'h4, 8'hC0, "R3");

    // R10 field decode
    wr(4'h9, 8'h01); wr(4'hC, 8'h0A); wr(4'h6, 8'h21); wr(4'hA, 8'h80);
    chk("R10 dir_reverse", {7'b0, dir_reverse}, 8'h01);
    chk("R10 delay_target", {4'b0, delay_target}, 8'h0A);
    chk("R10 delay_comp_en", {7'b0, delay_comp_en}, 8'h00);
    chk("R10 ocp_action", {6'b0, ocp_action}, 8'h01);
    chk("R10 ocp_deglitch", {6'b0, ocp_deglitch}, 8'h02);
    chk("R10 tach_div", {6'b0, tach_div}, 8'h02);

    // R8 strobe
    wr(4'h4, 8'h81);
    chk("R8 strobe high", {7'b0, clr_fault_pulse}, 8'h01);
    @(posedge clk); #1;
    chk("R8 strobe low", {7'b0, clr_fault_pulse}, 8'h00);
    rd(4'h4, 8'h80, "R8");

    // R9 writes outside range
    wr(4'hD, 8'h06); wr(4'h2, 8'h06); wr(4'h0, 8'hFF);
    chk("R9 lock untouched", {7'b0, bank_locked}, 8'h00);
    rd(4'h9, 8'h01, "R9"); rd(4'h3, 8'h00, "R9"); rd(4'hD, 8'h00, "R9");

    // R4 lock
    wr(4'h3, 8'h06);
    chk("R4 locked", {7'b0, bank_locked}, 8'h01);
    rd(4'h3, 8'h06, "R4");
    // R5 writes dropped
    wr(4'h9, 8'h00);
    rd(4'h9, 8'h01, "R5");
    chk("R5 dir_reverse", {7'b0, dir_reverse}, 8'h01);
    wr(4'h4, 8'h01);
    chk("R5 no strobe", {7'b0, clr_fault_pulse}, 8'h00);
    rd(4'h4, 8'h80, "R5");
    wr(4'hC, 8'hFF);
    rd(4'hC, 8'h0A, "R5");

    // R7 other codes while locked
    wr(4'h3, 8'hFD);
    chk("R7 stays locked", {7'b0, bank_locked}, 8'h01);
    rd(4'h3, 8'h05, "R7");
    wr(4'h3, 8'h00);
    chk("R7 stays locked 0", {7'b0, bank_locked}, 8'h01);

    // R6 unlock
    wr(4'h3, 8'h03);
    chk("R6 unlocked", {7'b0, bank_locked}, 8'h00);
    wr(4'h9, 8'h00);
    rd(4'h9, 8'h00, "R6");

    // R7 other code while unlocked
    wr(4'h3, 8'h07);
    chk("R7 stays unlocked", {7'b0, bank_locked}, 8'h00);
    rd(4'h3, 8'h07, "R7");
    // R4 relock with upper bits set
    wr(4'h3, 8'h0E);
    chk("R4 relocked", {7'b0, bank_locked}, 8'h01);
    rd(4'h3, 8'h06, "R7");

    @(posedge clk); #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule